// File: doc/BRIEF.md
# Single-Wire Slave Slot Engine with Two Speeds

This block is the bit-level front end of a slave on a single-wire, open-drain bus. It watches an already synchronised copy of the bus level and drives one pull-down enable. All timing is counted in ticks of a 1 µs enable pulse. It turns each master-started time slot into one bit event. When the upper layer arms a read of a 0 bit, it holds the bus low through the master's sampling window. It also recognises bus resets, answers them with a presence pulse, and tells the upper layer which kind of reset it saw.

Two complete timing sets are built in: a regular one and a faster one used in overdrive. The upper layer gives the current speed on `od_mode`. The engine latches that flag at each falling edge and uses it for the whole slot. A short low in overdrive is a reset that keeps the fast speed. A long low is always a reset back to regular speed, and the engine reports it as an overdrive exit when it happens at the fast speed. The presence pulse after each reset uses the timing set of the speed that is in force once the reset is decoded.

Top module: `owire_slot_engine`

## Requirements
- R1: While `rst` is high and in the cycle after it is released, `pull_low`, `bit_valid`, `rst_evt`, `rst_is_od` and `od_exit` are all 0.
- R2: The first low cycle seen while idle starts a slot. That slot gives exactly one single-cycle `bit_valid` pulse, taken when the tick counter started at the edge reaches the sample time (15 regular, 2 overdrive). `bit_val` is the level of `line_in` at that point: 1 for high, 0 for low.
- R3: When `rd_en`=1 and `rd_bit`=0 at the falling edge, `pull_low` is 1 for exactly T_DV+1 ticks starting the cycle after the edge (16 regular, 3 overdrive), so the bit event of that slot reads 0. With `rd_en`=0, or with `rd_bit`=1, the slot does not drive `pull_low`.
- R4: A low of 480 ticks or more gives one `rst_evt` pulse with `rst_is_od`=0 in the cycle after the line rises. The bit event of that low's slot (value 0) comes before it.
- R5: After a reset event the line stays released. The presence pull-down then starts between T_PDW and T_PDW+3 ticks after the rise (T_PDW = 30 regular, 3 overdrive) and lasts exactly T_PRES ticks (120 regular, 12 overdrive).
- R6: With `od_mode`=1 at the falling edge, a low of 48 to 80 ticks (both ends included) gives `rst_evt` with `rst_is_od`=1 and `od_exit`=0. Its presence pulse uses the overdrive set.
- R7: Any other low gives no reset event and no pull-down, only its bit event, and the next slot is decoded normally. At regular speed this means anything below 480 ticks. In overdrive it means anything below 48 ticks, or from 81 to 479 ticks.
- R8: A low of 480 ticks or more that began with `od_mode`=1 gives `rst_evt` with `rst_is_od`=0 and `od_exit`=1, followed by a presence pulse with regular timing. `od_exit` is never 1 without `rst_evt`, and never together with `rst_is_od`.
- R9: The engine has released `pull_low` before it waits for a new edge, so its own read-0 drive or presence pulse never starts a slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_us | input | 1 | One-cycle enable, once per microsecond |
| line_in | input | 1 | Synchronised bus level, 1 = high |
| od_mode | input | 1 | Overdrive speed selected by the upper layer |
| rd_en | input | 1 | The next slot is a read slot |
| rd_bit | input | 1 | Bit to send in the next read slot |
| pull_low | output | 1 | Open-drain pull-down enable |
| bit_valid | output | 1 | One-cycle pulse per decoded slot |
| bit_val | output | 1 | Line level at the sample point |
| rst_evt | output | 1 | One-cycle pulse per accepted reset |
| rst_is_od | output | 1 | Reset was a short overdrive reset that keeps speed |
| od_exit | output | 1 | Long reset that ended overdrive |

## Verification
The bench uses the default timing parameters, and `tick_us` is high on every clock. One tick is therefore one cycle, so the bench can place each low length on exact tick counts. This puts the reset boundaries within reach at 479/480 ticks and at 47/48/80/81 ticks in overdrive. It also allows exact checks on the read-0 hold length and the presence pulse length for both timing sets.

// File: rtl/owire_pkg.sv
package owire_pkg;
  localparam int TW = 16;
  typedef logic [TW-1:0] tval_t;

  typedef struct packed {
    tval_t sample;
    tval_t dv;
    tval_t pd_wait;
    tval_t pres;
  } slot_tim_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SLOT,
    ST_TAIL,
    ST_PDW,
    ST_PRES
  } eng_st_t;
endpackage

// File: rtl/owire_timing_sel.sv
module owire_timing_sel
  import owire_pkg::*;
#(
  parameter int R_SAMPLE = 15,
  parameter int R_DV     = 15,
  parameter int R_PDW    = 30,
  parameter int R_PRES   = 120,
  parameter int O_SAMPLE = 2,
  parameter int O_DV     = 2,
  parameter int O_PDW    = 3,
  parameter int O_PRES   = 12
) (
  input  logic      od_i,
  output slot_tim_t tim_o
);
  localparam slot_tim_t SET_R = '{sample: tval_t'(R_SAMPLE), dv: tval_t'(R_DV),
                                  pd_wait: tval_t'(R_PDW), pres: tval_t'(R_PRES)};
  localparam slot_tim_t SET_O = '{sample: tval_t'(O_SAMPLE), dv: tval_t'(O_DV),
                                  pd_wait: tval_t'(O_PDW), pres: tval_t'(O_PRES)};

  assign tim_o = od_i ? SET_O : SET_R;
endmodule

// File: rtl/owire_us_timer.sv
module owire_us_timer #(
  parameter int CMAX = 480,
  parameter int CW   = $clog2(CMAX + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          clr,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] LIM = CW'(CMAX);

  logic [CW-1:0] cnt_q;

  // Saturating microsecond counter; a stuck-low bus cannot wrap it.
  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt_q <= '0;
    else if (tick && cnt_q != LIM)
      cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/owire_slot_engine.sv
module owire_slot_engine
  import owire_pkg::*;
#(
  parameter int R_SAMPLE   = 15,
  parameter int R_DV       = 15,
  parameter int R_PDW      = 30,
  parameter int R_PRES     = 120,
  parameter int O_SAMPLE   = 2,
  parameter int O_DV       = 2,
  parameter int O_PDW      = 3,
  parameter int O_PRES     = 12,
  parameter int RST_LONG   = 480,
  parameter int OD_RST_MIN = 48,
  parameter int OD_RST_MAX = 80
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_us,
  input  logic line_in,
  input  logic od_mode,
  input  logic rd_en,
  input  logic rd_bit,
  output logic pull_low,
  output logic bit_valid,
  output logic bit_val,
  output logic rst_evt,
  output logic rst_is_od,
  output logic od_exit
);
  localparam int CNT_MAX = RST_LONG;
  localparam int CW      = $clog2(CNT_MAX + 1);

  eng_st_t       st_q, st_n;
  logic [CW-1:0] cnt;
  logic          clr;
  slot_tim_t     tim;
  int            low_len;

  logic pull_q, pull_n;
  logic bv_q, bv_n, bval_q, bval_n;
  logic re_q, re_n, rod_q, rod_n, ox_q, ox_n;
  logic drv_q, drv_n, odc_q, odc_n;

  owire_timing_sel #(
    .R_SAMPLE(R_SAMPLE), .R_DV(R_DV), .R_PDW(R_PDW), .R_PRES(R_PRES),
    .O_SAMPLE(O_SAMPLE), .O_DV(O_DV), .O_PDW(O_PDW), .O_PRES(O_PRES)
  ) u_tsel (
    .od_i (odc_q),
    .tim_o(tim)
  );

  owire_us_timer #(.CMAX(CNT_MAX), .CW(CW)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .tick (tick_us),
    .clr  (clr),
    .cnt_o(cnt)
  );

  // Length of the current low in ticks (counter restarts one cycle after the edge).
  assign low_len = int'(cnt) + 1;

  always_comb begin
    st_n   = st_q;
    clr    = 1'b0;
    pull_n = 1'b0;
    bv_n   = 1'b0;
    bval_n = bval_q;
    re_n   = 1'b0;
    rod_n  = 1'b0;
    ox_n   = 1'b0;
    drv_n  = drv_q;
    odc_n  = odc_q;
    case (st_q)
      ST_IDLE: begin
        // R2: a falling edge starts the slot timing; R3: read-0 drive begins at once
        if (!line_in) begin
          st_n   = ST_SLOT;
          clr    = 1'b1;
          odc_n  = od_mode;
          drv_n  = rd_en & ~rd_bit;
          pull_n = rd_en & ~rd_bit;
        end
      end
      ST_SLOT: begin
        pull_n = drv_q && (int'(cnt) < int'(tim.dv));
        if (int'(cnt) >= int'(tim.sample)) begin
          bv_n   = 1'b1;
          bval_n = line_in;
          st_n   = ST_TAIL;
        end
      end
      ST_TAIL: begin
        // R9: drive already released here; wait for the rise and classify the low
        if (line_in) begin
          clr = 1'b1;
          if (low_len >= RST_LONG) begin
            re_n  = 1'b1;
            ox_n  = odc_q;
            odc_n = 1'b0;
            st_n  = ST_PDW;
          end else if (odc_q && low_len >= OD_RST_MIN && low_len <= OD_RST_MAX) begin
            re_n  = 1'b1;
            rod_n = 1'b1;
            st_n  = ST_PDW;
          end else begin
            st_n = ST_IDLE;
          end
        end
      end
      ST_PDW: begin
        if (int'(cnt) >= int'(tim.pd_wait)) begin
          st_n   = ST_PRES;
          clr    = 1'b1;
          pull_n = 1'b1;
        end
      end
      ST_PRES: begin
        pull_n = 1'b1;
        if (low_len >= int'(tim.pres)) begin
          pull_n = 1'b0;
          st_n   = ST_IDLE;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      pull_q <= 1'b0;
      bv_q   <= 1'b0;
      bval_q <= 1'b0;
      re_q   <= 1'b0;
      rod_q  <= 1'b0;
      ox_q   <= 1'b0;
      drv_q  <= 1'b0;
      odc_q  <= 1'b0;
    end else begin
      st_q   <= st_n;
      pull_q <= pull_n;
      bv_q   <= bv_n;
      bval_q <= bval_n;
      re_q   <= re_n;
      rod_q  <= rod_n;
      ox_q   <= ox_n;
      drv_q  <= drv_n;
      odc_q  <= odc_n;
    end
  end

  assign pull_low  = pull_q;
  assign bit_valid = bv_q;
  assign bit_val   = bval_q;
  assign rst_evt   = re_q;
  assign rst_is_od = rod_q;
  assign od_exit   = ox_q;
endmodule

// File: rtl/owire_slot_engine_chk.sv
module owire_slot_engine_chk
  import owire_pkg::*;
(
  input logic    clk,
  input logic    rst,
  input logic    pull_low,
  input logic    bit_valid,
  input logic    rst_evt,
  input logic    rst_is_od,
  input logic    od_exit,
  input eng_st_t st
);
  p_bit_single_r2: assert property (@(posedge clk) disable iff (rst)
    bit_valid |=> !bit_valid);

  p_evt_apart_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({bit_valid, rst_evt}));

  p_pres_after_r5: assert property (@(posedge clk) disable iff (rst)
    rst_evt |-> !pull_low);

  p_od_keep_r6: assert property (@(posedge clk) disable iff (rst)
    rst_is_od |-> (rst_evt && !od_exit));

  p_od_exit_r8: assert property (@(posedge clk) disable iff (rst)
    od_exit |-> (rst_evt && !rst_is_od));

  p_idle_released_r9: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE) |-> !pull_low);
endmodule

bind owire_slot_engine owire_slot_engine_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .pull_low (pull_low),
  .bit_valid(bit_valid),
  .rst_evt  (rst_evt),
  .rst_is_od(rst_is_od),
  .od_exit  (od_exit),
  .st       (st_q)
);

// File: tb/owire_slot_engine_test.sv
module owire_slot_engine_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, m_low, od_mode, rd_en, rd_bit;
  logic pull_low, bit_valid, bit_val, rst_evt, rst_is_od, od_exit;
  logic line_in;
  assign line_in = ~(m_low | pull_low);

  owire_slot_engine uut (
    .clk(clk), .rst(rst), .tick_us(1'b1), .line_in(line_in), .od_mode(od_mode),
    .rd_en(rd_en), .rd_bit(rd_bit), .pull_low(pull_low), .bit_valid(bit_valid),
    .bit_val(bit_val), .rst_evt(rst_evt), .rst_is_od(rst_is_od), .od_exit(od_exit)
  );

  typedef enum int {K_BIT = 1, K_RST = 2, K_PULL = 3} kind_e;
  typedef struct { kind_e k; int v; string req; } exp_t;
  exp_t q[$];
  int n_chk = 0, n_fail = 0, plen = 0;
  bit done = 0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic expect_item(kind_e k, int v, string req);
    exp_t e;
    e.k = k; e.v = v; e.req = req;
    q.push_back(e);
  endtask

  // Event code: kind*1000 + value; reset value = rst_is_od*2 + od_exit.
  task automatic take(kind_e k, int v);
    exp_t e;
    if (q.size() == 0) begin
      check(1'b0, "R7", "unexpected event", int'(k) * 1000 + v, 0);
    end else begin
      e = q.pop_front();
      check(e.k == k && e.v == v, e.req, "event", int'(k) * 1000 + v, int'(e.k) * 1000 + e.v);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      if (bit_valid) take(K_BIT, int'(bit_val));
      if (rst_evt) take(K_RST, int'(rst_is_od) * 2 + int'(od_exit));
      if (pull_low) plen++;
      else if (plen > 0) begin
        take(K_PULL, plen);
        plen = 0;
      end
    end
  end

  task automatic slot(int len);
    @(negedge clk) m_low = 1'b1;
    repeat (len) @(negedge clk);
    m_low = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic settle(int n, string req);
    idle(n);
    check(q.size() == 0, req, "pending events", q.size(), 0);
  endtask

  task automatic reset_seq(int len, int pdw, int pres, int rv, string req);
    int g;
    expect_item(K_BIT, 0, "R4");
    expect_item(K_RST, rv, req);
    expect_item(K_PULL, pres, "R5");
    slot(len);
    g = 0;
    while (!pull_low && g < 1000) begin
      @(negedge clk);
      g++;
    end
    check(g >= pdw && g <= pdw + 3, "R5", "presence start gap", g, pdw + 3);
    settle(pres + 20, req);
  endtask

  initial begin
    rst = 1'b1; m_low = 1'b0; od_mode = 1'b0; rd_en = 1'b0; rd_bit = 1'b0;
    idle(4);
    check(pull_low == 0 && bit_valid == 0 && rst_evt == 0 && rst_is_od == 0 && od_exit == 0,
          "R1", "outputs in reset", int'({pull_low, bit_valid, rst_evt, rst_is_od, od_exit}), 0);
    rst = 1'b0;
    @(negedge clk);
    check(pull_low == 0 && bit_valid == 0 && rst_evt == 0,
          "R1", "outputs after reset", int'({pull_low, bit_valid, rst_evt}), 0);

    // Regular-speed write slots (R2)
    expect_item(K_BIT, 1, "R2"); slot(5);  settle(30, "R2");
    expect_item(K_BIT, 0, "R2"); slot(60); settle(30, "R2");
    expect_item(K_BIT, 1, "R2"); slot(16); settle(30, "R2");
    expect_item(K_BIT, 0, "R2"); slot(17); settle(30, "R2");

    // Read slots (R3, R9: one bit event only per driven slot)
    rd_en = 1'b1; rd_bit = 1'b1;
    expect_item(K_BIT, 1, "R3"); slot(1); settle(30, "R3");
    rd_bit = 1'b0;
    expect_item(K_BIT, 0, "R3"); expect_item(K_PULL, 16, "R3"); slot(1); settle(30, "R9");
    rd_en = 1'b0;

    // Regular reset and near misses (R4, R5, R7)
    reset_seq(480, 30, 120, 0, "R4");
    expect_item(K_BIT, 0, "R7"); slot(479); settle(40, "R7");
    expect_item(K_BIT, 0, "R7"); slot(60);  settle(40, "R7");
    expect_item(K_BIT, 1, "R7"); slot(3);   settle(30, "R7");

    // Overdrive slots
    od_mode = 1'b1;
    expect_item(K_BIT, 1, "R2"); slot(1); settle(10, "R2");
    expect_item(K_BIT, 0, "R2"); slot(8); settle(10, "R2");
    rd_en = 1'b1; rd_bit = 1'b0;
    expect_item(K_BIT, 0, "R3"); expect_item(K_PULL, 3, "R3"); slot(1); settle(10, "R3");
    rd_en = 1'b0;

    // Overdrive resets (R6, R7)
    reset_seq(60, 3, 12, 2, "R6");
    reset_seq(48, 3, 12, 2, "R6");
    reset_seq(80, 3, 12, 2, "R6");
    expect_item(K_BIT, 0, "R7"); slot(47);  settle(20, "R7");
    expect_item(K_BIT, 0, "R7"); slot(81);  settle(20, "R7");
    expect_item(K_BIT, 0, "R7"); slot(300); settle(20, "R7");

    // Long reset leaves overdrive (R8)
    reset_seq(480, 30, 120, 1, "R8");
    od_mode = 1'b0;
    expect_item(K_BIT, 1, "R2"); slot(5); settle(30, "R2");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(20 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule